// File: doc/BRIEF.md
# Instruction Prefetch and Alignment Buffer

This block is the fetch stage in front of the decoder of a three-stage pipelined core. It keeps a small ring of three 32-bit words of program code. It fills that ring either with word-aligned 32-bit reads from a program memory port, or by joining four single-byte reads when code runs from an 8-bit RAM port. The decoder sees a window of up to five contiguous bytes that starts at the current program counter, together with a count of how many of those bytes are valid. Each cycle the decoder returns how many bytes it used (0 to 5). The buffer moves its read position by that amount, and it frees a word once every byte in that word has been used.

Both memory ports answer through a stall input, and a fetch cycle lasts as long as stall is high. A taken branch flushes the ring, and fetching restarts from the word that holds the target. The target's byte offset within that first word hides the bytes below it. An input from the data side blocks RAM fetches in any cycle where the data path owns the RAM port. An instruction that reaches into a word not yet loaded simply sees a smaller valid count. The decoder waits until the count is large enough.

Top module: `ifetch_align_buf`

## Requirements
- R1: While reset is held and just after it, the valid count is 0, the program counter equals the parameter RESET_PC, and a 32-bit fetch of the aligned word holding RESET_PC is requested.
- R2: In 32-bit mode every request address has bits [1:0] equal to 0. Each accepted word moves the address up by 4. Window byte k (bits 8k+7:8k) holds the code byte at address pc+k, lowest address in bits [7:0].
- R3: When all three words hold unconsumed bytes, no request is made on either memory port.
- R4: In RAM mode only the byte port requests, at consecutive byte addresses. Four accepted bytes make one word, so twelve accepted bytes fill an empty ring, and the request then drops.
- R5: The valid count equals the smaller of 5 and the number of loaded bytes at or above the program counter. An instruction that crosses into a word still being fetched sees only the bytes below that word until it arrives.
- R6: The program counter moves by the consume count each cycle. A word stays occupied, and blocks a refill, until its last byte is consumed.
- R7: While a port's stall input is high, that port's request and address stay unchanged and no word is loaded.
- R8: In a cycle where the data side is busy, no RAM request is made, and the byte being assembled is not advanced.
- R9: A redirect empties the ring. In the next cycle the valid count is 0, the program counter is the target, and the request address is the target with bits [1:0] cleared. After the first word arrives, window byte 0 is the byte at the target, and the valid count excludes the bytes below the target offset.
- R10: When a redirect coincides with an accepted fetch or a nonzero consume count, the redirect wins. The fetched word is dropped, and the program counter is the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_i | input | 1 | Taken branch: flush and restart at redirect_pc_i |
| redirect_pc_i | input | ADDR_W | Branch target byte address |
| redirect_ram_i | input | 1 | Target code lives behind the 8-bit RAM port |
| pm_req_o | output | 1 | 32-bit program memory read request |
| pm_addr_o | output | ADDR_W | Word-aligned program memory address |
| pm_rdata_i | input | 32 | Program memory word, byte at lowest address in [7:0] |
| pm_stall_i | input | 1 | Program memory not ready; extends the cycle |
| rm_req_o | output | 1 | RAM byte read request for code |
| rm_addr_o | output | ADDR_W | RAM byte address |
| rm_rdata_i | input | 8 | RAM read byte |
| rm_stall_i | input | 1 | RAM not ready; extends the cycle |
| data_busy_i | input | 1 | Data side owns the RAM port this cycle |
| win_bytes_o | output | 40 | Five-byte decode window starting at pc_o |
| win_cnt_o | output | 3 | Number of valid window bytes, 0 to 5 |
| pc_o | output | ADDR_W | Address of window byte 0 |
| consume_i | input | 3 | Bytes taken by the decoder this cycle |

## Verification
The two functions that can fall in the same cycle are a redirect and the arrival of a fetched word, with a nonzero consume count added on top. The bench provokes this by leaving the program memory port unstalled while a request is pending, and raising redirect together with a consume of two bytes. It then checks that the next cycle shows an empty window, the new target as program counter, and an aligned request for the target word. One cycle later, window byte 0 must be the target's byte and not a byte of the word that was dropped.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int WIN_BYTES  = 5;
  localparam int WIN_W      = 8 * WIN_BYTES;
  localparam int WCNT_W     = 3;

  typedef logic [7:0]        byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifb_fetch_ctl.sv
module ifb_fetch_ctl
  import ifb_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [23:0] RESET_PC = 24'h008000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              flush_ram_i,
  input  logic              slot_free_i,
  output logic              pm_req_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  input  word_t             pm_rdata_i,
  input  logic              pm_stall_i,
  output logic              rm_req_o,
  output logic [ADDR_W-1:0] rm_addr_o,
  input  byte_t             rm_rdata_i,
  input  logic              rm_stall_i,
  input  logic              data_busy_i,
  output logic              fill_vld_o,
  output word_t             fill_word_o
);
  localparam logic [ADDR_W-1:0] RST_WADDR = {RESET_PC[ADDR_W-1:2], 2'b00};

  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              ram_q, ram_d;
  logic [1:0]        bidx_q, bidx_d;
  logic [23:0]       asm_q, asm_d;
  logic              pm_acc, rm_acc, rm_last;

  assign pm_req_o  = !ram_q && slot_free_i;
  assign rm_req_o  = ram_q && slot_free_i && !data_busy_i;
  assign pm_addr_o = faddr_q;
  assign rm_addr_o = faddr_q + ADDR_W'(bidx_q);

  assign pm_acc  = pm_req_o && !pm_stall_i;
  assign rm_acc  = rm_req_o && !rm_stall_i;
  assign rm_last = rm_acc && (bidx_q == 2'd3);

  assign fill_vld_o  = !flush_i && (pm_acc || rm_last);
  assign fill_word_o = ram_q ? {rm_rdata_i, asm_q} : pm_rdata_i;

  always_comb begin
    faddr_d = faddr_q;
    ram_d   = ram_q;
    bidx_d  = bidx_q;
    asm_d   = asm_q;
    if (flush_i) begin
      faddr_d = {flush_addr_i[ADDR_W-1:2], 2'b00};
      ram_d   = flush_ram_i;
      bidx_d  = 2'd0;
    end else if (fill_vld_o) begin
      faddr_d = faddr_q + ADDR_W'(WORD_BYTES);
      bidx_d  = 2'd0;
    end else if (rm_acc) begin
      bidx_d = bidx_q + 2'd1;
      asm_d[8*bidx_q +: 8] = rm_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= RST_WADDR;
      ram_q   <= 1'b0;
      bidx_q  <= 2'd0;
    end else begin
      faddr_q <= faddr_d;
      ram_q   <= ram_d;
      bidx_q  <= bidx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rm_acc) asm_q <= asm_d;
  end
endmodule

// File: rtl/ifb_word_ring.sv
module ifb_word_ring
  import ifb_pkg::*;
#(
  parameter int          NWORDS   = 3,
  parameter logic [1:0]  RST_OFF  = 2'd0,
  localparam int         PTR_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int         CNT_W    = $clog2(NWORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [1:0]       flush_off_i,
  input  logic             fill_vld_i,
  input  word_t            fill_word_i,
  input  logic [2:0]       consume_i,
  output word_t            head_word_o,
  output word_t            next_word_o,
  output logic [CNT_W-1:0] nvalid_o,
  output logic [1:0]       off_o,
  output logic             slot_free_o
);
  word_t            slot_q [NWORDS];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, wr_ptr, nx_ptr;
  logic [CNT_W-1:0] nvalid_q, nvalid_d;
  logic [1:0]       off_q, off_d;
  logic [3:0]       pos;
  logic [1:0]       freed;
  logic             wr_en;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    return PTR_W'(s % NWORDS);
  endfunction

  assign wr_ptr = ptr_add(rd_ptr_q, int'(nvalid_q));
  assign nx_ptr = ptr_add(rd_ptr_q, 1);
  assign pos    = {2'b00, off_q} + {1'b0, consume_i};
  assign freed  = pos[3:2];
  assign wr_en  = fill_vld_i && !flush_i;

  always_comb begin
    if (flush_i) begin
      nvalid_d = '0;
      rd_ptr_d = '0;
      off_d    = flush_off_i;
    end else begin
      nvalid_d = nvalid_q - CNT_W'(freed) + CNT_W'(wr_en);
      rd_ptr_d = ptr_add(rd_ptr_q, int'(freed));
      off_d    = pos[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvalid_q <= '0;
      rd_ptr_q <= '0;
      off_q    <= RST_OFF;
    end else begin
      nvalid_q <= nvalid_d;
      rd_ptr_q <= rd_ptr_d;
      off_q    <= off_d;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(i))) slot_q[i] <= fill_word_i;
    end
  end

  assign head_word_o = slot_q[rd_ptr_q];
  assign next_word_o = slot_q[nx_ptr];
  assign nvalid_o    = nvalid_q;
  assign off_o       = off_q;
  assign slot_free_o = (int'(nvalid_q) < NWORDS);
endmodule

// File: rtl/ifb_byte_window.sv
module ifb_byte_window
  import ifb_pkg::*;
#(
  parameter  int NWORDS = 3,
  localparam int CNT_W  = $clog2(NWORDS + 1)
) (
  input  word_t             head_word_i,
  input  word_t             next_word_i,
  input  logic [CNT_W-1:0]  nvalid_i,
  input  logic [1:0]        off_i,
  output logic [WIN_W-1:0]  win_o,
  output logic [WCNT_W-1:0] cnt_o
);
  logic [2*WORD_W-1:0] pair, shifted;
  int                  avail;

  assign pair    = {next_word_i, head_word_i};
  assign shifted = pair >> {off_i, 3'b000};

  always_comb begin
    if (nvalid_i == '0) avail = 0;
    else                avail = WORD_BYTES * int'(nvalid_i) - int'(off_i);
    cnt_o = (avail > WIN_BYTES) ? WCNT_W'(WIN_BYTES) : WCNT_W'(avail);
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    assign win_o[8*b +: 8] = (WCNT_W'(b) < cnt_o) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/ifetch_align_buf.sv
module ifetch_align_buf
  import ifb_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          NWORDS   = 3,
  parameter logic [23:0] RESET_PC = 24'h008000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_pc_i,
  input  logic              redirect_ram_i,
  output logic              pm_req_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  input  logic [31:0]       pm_rdata_i,
  input  logic              pm_stall_i,
  output logic              rm_req_o,
  output logic [ADDR_W-1:0] rm_addr_o,
  input  logic [7:0]        rm_rdata_i,
  input  logic              rm_stall_i,
  input  logic              data_busy_i,
  output logic [39:0]       win_bytes_o,
  output logic [2:0]        win_cnt_o,
  output logic [ADDR_W-1:0] pc_o,
  input  logic [2:0]        consume_i
);
  localparam int CNT_W = $clog2(NWORDS + 1);

  logic              slot_free, fill_vld;
  word_t             fill_word, head_word, next_word;
  logic [CNT_W-1:0]  ring_nvalid;
  logic [1:0]        ring_off;
  logic [2:0]        cons_eff;
  logic [ADDR_W-1:0] pc_q, pc_d;

  assign cons_eff = (consume_i > win_cnt_o) ? win_cnt_o : consume_i;

  ifb_fetch_ctl #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (redirect_i),
    .flush_addr_i (redirect_pc_i),
    .flush_ram_i  (redirect_ram_i),
    .slot_free_i  (slot_free),
    .pm_req_o     (pm_req_o),
    .pm_addr_o    (pm_addr_o),
    .pm_rdata_i   (pm_rdata_i),
    .pm_stall_i   (pm_stall_i),
    .rm_req_o     (rm_req_o),
    .rm_addr_o    (rm_addr_o),
    .rm_rdata_i   (rm_rdata_i),
    .rm_stall_i   (rm_stall_i),
    .data_busy_i  (data_busy_i),
    .fill_vld_o   (fill_vld),
    .fill_word_o  (fill_word)
  );

  ifb_word_ring #(.NWORDS(NWORDS), .RST_OFF(RESET_PC[1:0])) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (redirect_i),
    .flush_off_i  (redirect_pc_i[1:0]),
    .fill_vld_i   (fill_vld),
    .fill_word_i  (fill_word),
    .consume_i    (cons_eff),
    .head_word_o  (head_word),
    .next_word_o  (next_word),
    .nvalid_o     (ring_nvalid),
    .off_o        (ring_off),
    .slot_free_o  (slot_free)
  );

  ifb_byte_window #(.NWORDS(NWORDS)) u_win (
    .head_word_i  (head_word),
    .next_word_i  (next_word),
    .nvalid_i     (ring_nvalid),
    .off_i        (ring_off),
    .win_o        (win_bytes_o),
    .cnt_o        (win_cnt_o)
  );

  always_comb begin
    if (redirect_i) pc_d = redirect_pc_i;
    else            pc_d = pc_q + ADDR_W'(cons_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= ADDR_W'(RESET_PC);
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
  parameter  int ADDR_W = 24,
  parameter  int NWORDS = 3,
  localparam int CNT_W  = $clog2(NWORDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redirect_i,
  input logic [ADDR_W-1:0] redirect_pc_i,
  input logic              pm_req_o,
  input logic [ADDR_W-1:0] pm_addr_o,
  input logic              pm_stall_i,
  input logic              rm_req_o,
  input logic              data_busy_i,
  input logic [2:0]        win_cnt_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [2:0]        consume_i,
  input logic [CNT_W-1:0]  nvalid_i
);
  AST_PM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req_o |-> (pm_addr_o[1:0] == 2'b00)); // R2

  AST_NO_REQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(nvalid_i) == NWORDS) |-> (!pm_req_o && !rm_req_o)); // R3

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_req_o && rm_req_o)); // R4

  AST_EMPTY_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (nvalid_i == '0) |-> (win_cnt_o == 3'd0)); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && (consume_i <= win_cnt_o)) |=> (pc_o == $past(pc_o) + ADDR_W'($past(consume_i)))); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req_o && pm_stall_i && !redirect_i) |=> (redirect_i || (pm_req_o && $stable(pm_addr_o)))); // R7

  AST_BUSY_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy_i |-> !rm_req_o); // R8

  AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> ((pc_o == $past(redirect_pc_i)) && (win_cnt_o == 3'd0))); // R9

  AST_FLUSH_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_i && pm_req_o && !pm_stall_i) |=> (nvalid_i == '0)); // R10
endmodule

bind ifetch_align_buf ifb_checker #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .redirect_i    (redirect_i),
  .redirect_pc_i (redirect_pc_i),
  .pm_req_o      (pm_req_o),
  .pm_addr_o     (pm_addr_o),
  .pm_stall_i    (pm_stall_i),
  .rm_req_o      (rm_req_o),
  .data_busy_i   (data_busy_i),
  .win_cnt_o     (win_cnt_o),
  .pc_o          (pc_o),
  .consume_i     (consume_i),
  .nvalid_i      (ring_nvalid)
);

// File: tb/tb_ifetch_align_buf.sv
module tb_ifetch_align_buf;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              redirect_i;
  logic [ADDR_W-1:0] redirect_pc_i;
  logic              redirect_ram_i;
  logic              pm_req_o;
  logic [ADDR_W-1:0] pm_addr_o;
  logic [31:0]       pm_rdata_i;
  logic              pm_stall_i;
  logic              rm_req_o;
  logic [ADDR_W-1:0] rm_addr_o;
  logic [7:0]        rm_rdata_i;
  logic              rm_stall_i;
  logic              data_busy_i;
  logic [39:0]       win_bytes_o;
  logic [2:0]        win_cnt_o;
  logic [ADDR_W-1:0] pc_o;
  logic [2:0]        consume_i;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mb(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign pm_rdata_i = {mb(pm_addr_o + 24'd3), mb(pm_addr_o + 24'd2),
                       mb(pm_addr_o + 24'd1), mb(pm_addr_o)};
  assign rm_rdata_i = mb(rm_addr_o);

  ifetch_align_buf #(.ADDR_W(ADDR_W), .NWORDS(3), .RESET_PC(24'h008000)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // window bytes must match code memory at pc
  task automatic chk_win(input string req, input int exp_cnt, input logic [ADDR_W-1:0] exp_pc);
    eq(req, "valid count", win_cnt_o, exp_cnt);
    eq(req, "pc", pc_o, exp_pc);
    for (int i = 0; i < exp_cnt; i++)
      eq(req, "window byte", win_bytes_o[8*i +: 8], mb(exp_pc + ADDR_W'(i)));
  endtask

  task automatic redirect(input logic [ADDR_W-1:0] tgt, input logic ram);
    redirect_i = 1'b1; redirect_pc_i = tgt; redirect_ram_i = ram;
    tick();
    redirect_i = 1'b0;
    #1;
  endtask

  task automatic t_reset_and_fill();
    rst_n = 1'b0;
    repeat (3) tick();
    chk_win("R1", 0, 24'h008000);
    rst_n = 1'b1;
    #1;
    eq("R1", "pm_req after reset", pm_req_o, 1);
    eq("R1", "pm_addr after reset", pm_addr_o, 24'h008000);
    tick();
    chk_win("R2", 4, 24'h008000);
    eq("R2", "next word address", pm_addr_o, 24'h008004);
    tick();
    chk_win("R2", 5, 24'h008000);
    eq("R2", "third word address", pm_addr_o, 24'h008008);
    tick();
    eq("R3", "pm_req when full", pm_req_o, 0);
    eq("R3", "rm_req when full", rm_req_o, 0);
    tick();
    eq("R3", "pm_req stays low", pm_req_o, 0);
  endtask

  task automatic t_consume();
    consume_i = 3'd3;
    tick();
    consume_i = 3'd0;
    #1;
    chk_win("R6", 5, 24'h008003);
    eq("R6", "no refill while word partly used", pm_req_o, 0);
    consume_i = 3'd1;
    tick();
    consume_i = 3'd0;
    #1;
    chk_win("R6", 5, 24'h008004);
    eq("R6", "refill after word freed", pm_req_o, 1);
    eq("R6", "refill address", pm_addr_o, 24'h00800C);
    tick();
    eq("R3", "full again", pm_req_o, 0);
  endtask

  task automatic t_stall();
    pm_stall_i = 1'b1;
    redirect(24'h000100, 1'b0);
    for (int i = 0; i < 3; i++) begin
      eq("R7", "count during stall", win_cnt_o, 0);
      eq("R7", "request held", pm_req_o, 1);
      eq("R7", "address held", pm_addr_o, 24'h000100);
      tick();
    end
    pm_stall_i = 1'b0;
    tick();
    chk_win("R7", 4, 24'h000100);
  endtask

  task automatic t_unaligned();
    redirect(24'h000203, 1'b0);
    chk_win("R9", 0, 24'h000203);
    eq("R9", "aligned target fetch", pm_addr_o, 24'h000200);
    tick();
    chk_win("R9", 1, 24'h000203);
    pm_stall_i = 1'b1;
    tick();
    tick();
    chk_win("R5", 1, 24'h000203);
    pm_stall_i = 1'b0;
    tick();
    chk_win("R5", 5, 24'h000203);
  endtask

  task automatic t_ram();
    redirect(24'h000041, 1'b1);
    eq("R4", "no word fetch in RAM mode", pm_req_o, 0);
    eq("R4", "first byte request", rm_req_o, 1);
    eq("R4", "first byte address", rm_addr_o, 24'h000040);
    tick();
    eq("R4", "second byte address", rm_addr_o, 24'h000041);
    tick();
    tick();
    eq("R4", "count before word complete", win_cnt_o, 0);
    tick();
    chk_win("R4", 3, 24'h000041);
    for (int i = 4; i < 11; i++) tick();
    eq("R4", "11th byte request", rm_req_o, 1);
    eq("R4", "12th byte address", rm_addr_o, 24'h00004B);
    tick();
    eq("R4", "request after 12 bytes", rm_req_o, 0);
    chk_win("R4", 5, 24'h000041);
  endtask

  task automatic t_busy();
    redirect(24'h000080, 1'b1);
    tick();
    tick();
    data_busy_i = 1'b1;
    #1;
    eq("R8", "no RAM request while busy", rm_req_o, 0);
    tick();
    tick();
    eq("R8", "count while busy", win_cnt_o, 0);
    data_busy_i = 1'b0;
    #1;
    eq("R8", "byte index held", rm_addr_o, 24'h000082);
    tick();
    tick();
    chk_win("R8", 4, 24'h000080);
  endtask

  task automatic t_collide();
    redirect(24'h000300, 1'b0);
    tick();
    chk_win("R10", 4, 24'h000300);
    eq("R10", "fetch pending", pm_req_o, 1);
    consume_i = 3'd2;
    redirect(24'h000404, 1'b0);
    consume_i = 3'd0;
    #1;
    chk_win("R10", 0, 24'h000404);
    eq("R10", "target word address", pm_addr_o, 24'h000404);
    tick();
    chk_win("R10", 4, 24'h000404);
  endtask

  initial begin
    rst_n = 1'b0; redirect_i = 1'b0; redirect_pc_i = '0; redirect_ram_i = 1'b0;
    pm_stall_i = 1'b0; rm_stall_i = 1'b0; data_busy_i = 1'b0; consume_i = 3'd0;
    t_reset_and_fill();
    t_consume();
    t_stall();
    t_unaligned();
    t_ram();
    t_busy();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule